// File: doc/BRIEF.md
# QRSS Test Pattern Generator and Checker

This block makes and checks a quasi-random test pattern on a serial bit stream. A 20-stage shift-register sequence is post-processed so that no run of zeros is longer than fourteen bits. The result goes out on `tx_bit` for transmit-side testing. On the receive side, a checker rebuilds the same sequence from the incoming bits and compares every following bit against its own prediction.

Both halves advance only when `bit_en` is high, so a serial interface of any rate can drive the block through a one-cycle strobe. The checker reports on one output, `det_flag`, with inverted polarity. The flag stays high while the checker hunts for the pattern and goes low once it has locked. After lock, each wrong bit gives one high pulse that lasts half a clock period, so an external counter can count bit errors straight from the flag. A loss-of-signal input forces the flag high.

Top module: `qrss_txrx`

## Requirements
- R1: While `rst_n` is low, `det_flag` is 1 and `tx_bit` shows the first pattern bit, which is 1 with the default seed.
- R2: The raw sequence obeys b[n] = b[n-17] XOR b[n-20]. Bit k of `GEN_SEED` holds b[-1-k], and the default seed is 1. Output bit n is `b[n] OR (b[n+1]..b[n+14] all zero)`, and n counts enabled cycles since reset.
- R3: `tx_bit` never shows more than 14 zeros in a row. With the default seed, the first 16 output bits are 1, 1 and then fourteen zeros.
- R4: While `bit_en` is 0, `tx_bit` holds its value and `rx_bit` is ignored: no error pulse appears and the lock state does not change.
- R5: Lock needs 32 consecutive received bits that match the prediction. So after reset or after a loss of lock, `det_flag` stays high for at least the next 31 enabled bits.
- R6: With an error-free pattern on `rx_bit`, the checker locks and drives `det_flag` low.
- R7: While locked, every mismatched bit drives `det_flag` high from the rising edge that samples it until the next falling edge. Back-to-back errors give one pulse each.
- R8: After lock, enabled bits are grouped into consecutive windows of 64, starting with the first bit after lock. Lock is lost on the bit that brings one window's error count above 6. Six or fewer errors in a window, or errors split across two windows, keep lock.
- R9: After lock is lost, the checker re-seeds from the received bits and locks again under the R5 rule.
- R10: While `rx_los` is 1, `det_flag` is 1 whatever the checker state. The checker keeps running, so the flag is low again as soon as `rx_los` drops while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its rising edge samples inputs, its falling edge ends error pulses |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit strobe; generator and checker advance only when high |
| rx_bit | input | 1 | Received serial bit, valid when `bit_en` is high |
| rx_los | input | 1 | Loss of signal; forces `det_flag` high |
| tx_bit | output | 1 | Current generated pattern bit |
| det_flag | output | 1 | High while unlocked or losing signal, low when locked, half-period high pulse per error |

## Verification
`tx_bit` is valid before each rising edge and moves to the next bit at an enabled edge. The bench therefore compares it against its own sequence model just before that edge. Lock and loss of lock show on `det_flag` right after the rising edge that samples the deciding bit, and an error pulse lasts only until the falling edge. For this reason every bit is observed twice: 2 ns after the rising edge, where a pulse must be high, and 2 ns after the falling edge, where only the lock state remains. `rx_los` acts on the flag without a register, and its effect is checked at both sample points of the same bit.

// File: rtl/qrss_pkg.sv
package qrss_pkg;

   typedef enum logic {
      DET_HUNT = 1'b0,
      DET_LOCK = 1'b1
   } det_state_e;

endpackage

// File: rtl/qrss_predict.sv
// Look-ahead of a two-tap recurrence from a window of past raw bits.
// hist[k] holds raw bit b[n-1-k]; produces raw b[n] and the zero-limited output bit.
module qrss_predict #(
   parameter int LEN  = 20,
   parameter int LAG  = 17,
   parameter int ZRUN = 14,
   localparam int LOW = LAG - 1 - ZRUN
) (
   input  logic [LEN-1:LOW] hist,
   output logic             raw_bit,
   output logic             out_bit
);

   if (LAG >= LEN || LAG < 2) begin : g_bad_lag
      $error("qrss_predict: LAG must lie in 2..LEN-1");
   end
   if (ZRUN < 1 || LOW < 0) begin : g_bad_zrun
      $error("qrss_predict: ZRUN must lie in 1..LAG-1");
   end

   logic [ZRUN:0] fut;

   // every future bit up to LAG-1 ahead depends on past bits only
   for (genvar j = 0; j <= ZRUN; j++) begin : g_ahead
      assign fut[j] = hist[LAG-1-j] ^ hist[LEN-1-j];
   end

   assign raw_bit = fut[0];
   assign out_bit = fut[0] | ~(|fut[ZRUN:1]);

endmodule

// File: rtl/qrss_gen.sv
module qrss_gen #(
   parameter int             LEN  = 20,
   parameter int             LAG  = 17,
   parameter int             ZRUN = 14,
   parameter logic [LEN-1:0] SEED = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   output logic tx_bit
);

   localparam int LOW = LAG - 1 - ZRUN;

   if (SEED == '0) begin : g_bad_seed
      $error("qrss_gen: SEED must be non-zero");
   end

   logic [LEN-1:0] hist_q;
   logic           raw_bit;

   qrss_predict #(.LEN(LEN), .LAG(LAG), .ZRUN(ZRUN)) u_pred (
      .hist    (hist_q[LEN-1:LOW]),
      .raw_bit (raw_bit),
      .out_bit (tx_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hist_q <= SEED;
      else if (bit_en) hist_q <= {hist_q[LEN-2:0], raw_bit};
   end

endmodule

// File: rtl/qrss_det.sv
module qrss_det
   import qrss_pkg::*;
#(
   parameter int LEN      = 20,
   parameter int LAG      = 17,
   parameter int ZRUN     = 14,
   parameter int LOCK_RUN = 32,
   parameter int WIN_LEN  = 64,
   parameter int ERR_LIM  = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic rx_bit,
   output logic locked,
   output logic err_tog
);

   localparam int LOW   = LAG - 1 - ZRUN;
   localparam int RUN_W = $clog2(LOCK_RUN);
   localparam int WIN_W = $clog2(WIN_LEN);
   localparam int ERR_W = $clog2(ERR_LIM + 2);

   if (LOCK_RUN < 2 || WIN_LEN < 2 || ERR_LIM < 1 || ERR_LIM >= WIN_LEN) begin : g_bad_cfg
      $error("qrss_det: need LOCK_RUN>=2, WIN_LEN>=2, 1<=ERR_LIM<WIN_LEN");
   end

   det_state_e       state_q;
   logic [LEN-1:0]   hist_q;
   logic [RUN_W-1:0] run_q;
   logic [WIN_W-1:0] win_q;
   logic [ERR_W-1:0] errs_q;
   logic [ERR_W-1:0] errs_sum;
   logic             tog_q;
   logic             raw_bit;
   logic             pred_bit;
   logic             mism;

   qrss_predict #(.LEN(LEN), .LAG(LAG), .ZRUN(ZRUN)) u_pred (
      .hist    (hist_q[LEN-1:LOW]),
      .raw_bit (raw_bit),
      .out_bit (pred_bit)
   );

   always_comb begin
      mism     = rx_bit ^ pred_bit;
      errs_sum = errs_q + {{(ERR_W-1){1'b0}}, mism};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DET_HUNT;
         hist_q  <= '0;
         run_q   <= '0;
         win_q   <= '0;
         errs_q  <= '0;
         tog_q   <= 1'b0;
      end else if (bit_en) begin
         case (state_q)
            DET_HUNT: begin
               hist_q <= {hist_q[LEN-2:0], rx_bit};
               if (mism) begin
                  run_q <= '0;
               end else if (run_q == RUN_W'(LOCK_RUN - 1)) begin
                  state_q <= DET_LOCK;
                  run_q   <= '0;
                  win_q   <= '0;
                  errs_q  <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end
            default: begin
               hist_q <= {hist_q[LEN-2:0], raw_bit};
               if (mism) tog_q <= ~tog_q;
               if (errs_sum > ERR_W'(ERR_LIM)) begin
                  state_q <= DET_HUNT;
                  run_q   <= '0;
               end else if (win_q == WIN_W'(WIN_LEN - 1)) begin
                  win_q  <= '0;
                  errs_q <= '0;
               end else begin
                  win_q  <= win_q + 1'b1;
                  errs_q <= errs_sum;
               end
            end
         endcase
      end
   end

   assign locked  = (state_q == DET_LOCK);
   assign err_tog = tog_q;

endmodule

// File: rtl/qrss_pulse.sv
// Turns each toggle of a rising-edge register into a pulse ending at the next falling edge.
module qrss_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic tog,
   output logic pulse
);

   logic trail_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) trail_q <= 1'b0;
      else        trail_q <= tog;
   end

   assign pulse = tog ^ trail_q;

endmodule

// File: rtl/qrss_txrx.sv
module qrss_txrx #(
   parameter int                  PRBS_LEN  = 20,
   parameter int                  PRBS_LAG  = 17,
   parameter int                  MAX_ZEROS = 14,
   parameter logic [PRBS_LEN-1:0] GEN_SEED  = 1,
   parameter int                  LOCK_RUN  = 32,
   parameter int                  WIN_LEN   = 64,
   parameter int                  ERR_LIM   = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic rx_bit,
   input  logic rx_los,
   output logic tx_bit,
   output logic det_flag
);

   logic det_locked;
   logic err_tog;
   logic err_pulse;

   qrss_gen #(
      .LEN (PRBS_LEN), .LAG (PRBS_LAG), .ZRUN (MAX_ZEROS), .SEED (GEN_SEED)
   ) u_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_en (bit_en),
      .tx_bit (tx_bit)
   );

   qrss_det #(
      .LEN (PRBS_LEN), .LAG (PRBS_LAG), .ZRUN (MAX_ZEROS),
      .LOCK_RUN (LOCK_RUN), .WIN_LEN (WIN_LEN), .ERR_LIM (ERR_LIM)
   ) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_en  (bit_en),
      .rx_bit  (rx_bit),
      .locked  (det_locked),
      .err_tog (err_tog)
   );

   qrss_pulse u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .tog   (err_tog),
      .pulse (err_pulse)
   );

   assign det_flag = rx_los | ~det_locked | err_pulse;

endmodule

// File: rtl/qrss_txrx_chk.sv
module qrss_txrx_chk #(
   parameter int MAX_ZEROS = 14
) (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic rx_los,
   input logic tx_bit,
   input logic det_flag,
   input logic lock_q,
   input logic tog_q
);

   localparam int ZW = $clog2(MAX_ZEROS + 2);

   logic [ZW-1:0] zrun_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             zrun_q <= '0;
      else if (bit_en) begin
         if (tx_bit)          zrun_q <= '0;
         else if (zrun_q != '1) zrun_q <= zrun_q + 1'b1;
      end
   end

   p_zero_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      zrun_q <= ZW'(MAX_ZEROS));

   p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(tx_bit));

   p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(lock_q));

   p_no_err_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(tog_q));

   p_hunt_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_q |-> det_flag);

   p_err_when_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tog_q) |-> $past(lock_q && bit_en));

   p_los_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_los |-> det_flag);

endmodule

bind qrss_txrx qrss_txrx_chk #(.MAX_ZEROS(MAX_ZEROS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_en   (bit_en),
   .rx_los   (rx_los),
   .tx_bit   (tx_bit),
   .det_flag (det_flag),
   .lock_q   (det_locked),
   .tog_q    (err_tog)
);

// File: tb/qrss_txrx_tb.sv
module qrss_txrx_tb;

   localparam int          NM        = 6000;
   localparam logic [19:0] SEED      = 20'h00001;
   localparam logic [15:0] START_PAT = 16'b1100_0000_0000_0000;
   localparam int          NROW      = 7;
   // {offset in window, consecutive errors, lock kept}
   localparam int TAB [NROW][3] = '{
      '{0, 6, 1}, '{0, 7, 0}, '{60, 8, 1}, '{58, 6, 1},
      '{57, 7, 0}, '{30, 1, 1}, '{61, 7, 1}
   };

   logic clk = 1'b0;
   logic rst_n, bit_en, rx_bit, rx_los;
   wire  tx_bit, det_flag;

   qrss_txrx #(.GEN_SEED(SEED)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .rx_bit   (rx_bit),
      .rx_los   (rx_los),
      .tx_bit   (tx_bit),
      .det_flag (det_flag)
   );

   always #5 clk = ~clk;

   int   checks = 0, fails = 0;
   int   n = 0, pos = 0, tx_bad = 0, zrun = 0, zmax = 0;
   logic hi, lo;
   logic raw_m [0:NM+40];

   function automatic logic model_o(int idx);
      logic z;
      z = 1'b1;
      for (int j = 1; j <= 14; j++) if (raw_m[idx+20+j]) z = 1'b0;
      return raw_m[idx+20] | z;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called 2 ns after a falling edge
   task automatic step(input logic en, input logic flip, input logic los);
      bit_en = en;
      rx_los = los;
      rx_bit = model_o(n) ^ flip;
      #1;
      if (tx_bit !== model_o(n)) tx_bad++;
      if (en) begin
         if (tx_bit) zrun = 0;
         else        zrun++;
         if (zrun > zmax) zmax = zrun;
      end
      @(posedge clk); #2 hi = det_flag;
      if (en) n++;
      @(negedge clk); #2 lo = det_flag;
   endtask

   task automatic lstep(input logic flip);
      step(1'b1, flip, 1'b0);
      pos = (pos + 1) % 64;
   endtask

   task automatic wait_lock(input string req);
      bit got;
      got = 1'b0;
      for (int i = 0; i < 200 && !got; i++) begin
         step(1'b1, 1'b0, 1'b0);
         if (lo == 1'b0) got = 1'b1;
      end
      chk(got, req, got, 1);
      pos = 0;
   endtask

   task automatic hunt_quiet(input string req);
      bit ok;
      ok = 1'b1;
      for (int i = 0; i < 31; i++) begin
         step(1'b1, 1'b0, 1'b0);
         if (!(hi && lo)) ok = 1'b0;
      end
      chk(ok, req, ok, 1);
   endtask

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      bit ok;
      int pulses;
      for (int k = 0; k < 20; k++) raw_m[19-k] = SEED[k];
      for (int i = 20; i <= NM + 40; i++) raw_m[i] = raw_m[i-17] ^ raw_m[i-20];

      rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b0; rx_los = 1'b0;
      repeat (3) @(negedge clk);
      #2;
      // R1 reset state
      chk(det_flag === 1'b1, "R1 flag in reset", det_flag, 1);
      chk(tx_bit === 1'b1, "R1 first tx bit", tx_bit, 1);
      rst_n = 1'b1;

      // R3 start pattern, R5 no early lock
      ok = 1'b1;
      for (int i = 0; i < 31; i++) begin
         if (i < 16) chk(tx_bit === START_PAT[15-i], "R3 start pattern", tx_bit, START_PAT[15-i]);
         step(1'b1, 1'b0, 1'b0);
         if (!(hi && lo)) ok = 1'b0;
      end
      chk(ok, "R5 flag high for first 31 bits", ok, 1);

      wait_lock("R6 lock on clean data");

      // R4 idle cycles with corrupt rx
      ok = 1'b1;
      for (int i = 0; i < 5; i++) begin
         step(1'b0, 1'b1, 1'b0);
         if (hi || lo) ok = 1'b0;
      end
      chk(ok, "R4 idle ignores rx", ok, 1);

      // R10 loss of signal override
      ok = 1'b1;
      for (int i = 0; i < 3; i++) begin
         lstep(1'b0);
         step(1'b0, 1'b0, 1'b1);
         if (!(hi && lo)) ok = 1'b0;
      end
      chk(ok, "R10 flag high under los", ok, 1);
      lstep(1'b0);
      chk(!hi && !lo, "R10 lock kept after los", {hi, lo}, 0);

      // table walk: error bursts at chosen window offsets
      for (int r = 0; r < NROW; r++) begin
         while (pos != 0) lstep(1'b0);
         repeat (TAB[r][0]) lstep(1'b0);
         pulses = 0;
         for (int e = 0; e < TAB[r][1]; e++) begin
            lstep(1'b1);
            if (hi && !lo) pulses++;
         end
         if (TAB[r][2] == 1) begin
            chk(lo == 1'b0, "R8 lock kept", lo, 0);
            chk(pulses == TAB[r][1], "R7 one pulse per error", pulses, TAB[r][1]);
         end else begin
            chk(lo == 1'b1, "R8 lock lost", lo, 1);
            chk(pulses == TAB[r][1] - 1, "R7 pulses before loss", pulses, TAB[r][1] - 1);
            hunt_quiet("R5 no early relock");
            wait_lock("R9 relock");
         end
      end

      chk(tx_bad == 0, "R2 tx sequence", tx_bad, 0);
      chk(zmax == 14, "R3 longest zero run", zmax, 14);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule